// File: doc/BRIEF.md
# Cipher Engine Command Queue Front End

This block sits between a host and a block-cipher engine. The host writes 32-bit command words into a five-entry inbound queue. The front end takes the words out in order and decodes each one from a packed layout: a 6-bit operation code in the top bits and operand fields below it. It then drives one-cycle start pulses and operand buses toward a DMA unit, a key-table loader and the cipher datapath. The DMA unit, the cipher core and the internal RAM are not part of the block. The bench stands in for them through a per-block done strobe and a DMA done strobe.

Some commands take a trailing word. A source-setup command captures the source address from the word after it. A memory-copy command takes its external address from the word after it. A cipher start is refused until a source address has been captured. While the engine runs, only the completion marker is taken from the queue. Every other word waits.

The host sees several status outputs: a queue-empty flag, a queue-full flag, an engine-busy flag and a DMA-busy flag. A write-one-to-clear interrupt status register gathers the error and completion events. An enable mask picks which of those events drive the single interrupt line.

Top module: `cq_front`

## Requirements
- R1: After synchronous reset the queue is empty and not full. Engine-busy and DMA-busy are low, interrupt status and enable read 0, every start pulse is low, irq is low and the captured source address is 0.
- R2: The queue keeps up to 5 words and releases them in write order, with q_full high while 5 are held. A write seen while 5 words are held is dropped and sets sticky status bit 1 (overflow). This holds even if a word leaves the queue in the same cycle.
- R3: Opcode 0x15 (bits 31:26) is a table load. It produces a one-cycle tbl_load pulse with tbl_sel from bit 24, tbl_ram from bit 23 and tbl_id from bits 22:17. Software forms that ID as 0x8 OR a 3-bit slot number.
- R4: Opcode 0x22 is a memory copy. It latches the direction from bit 25 (0 inbound, 1 outbound) and the word count from bits 24:12. The next queue word becomes dma_addr and triggers a one-cycle dma_start. dma_busy then stays high until dma_done, and that dma_done sets status bit 5.
- R5: Opcode 0x10 is a source setup. The next queue word is captured as eng_src and marks the address as valid.
- R6: Opcode 0x0E is a cipher start. With a valid address it pulses eng_start with eng_blocks equal to bits 11:0 plus 1 and consumes the address. Without one, the word is discarded and status bit 0 (illegal) is set.
- R7: eng_busy rises with eng_start and falls on the edge that takes the last requested blk_done. While it is high, only opcode 0x11 is taken from the queue.
- R8: Opcode 0x11 marks completion and sets status bit 4. If taken while the engine runs, bit 4 sets on the same edge that eng_busy falls. If taken while idle, bit 4 sets at once.
- R9: Any other opcode is discarded and sets status bit 0.
- R10: Writing irq_clr_data with irq_clr_wr clears each status bit written as 1. A bit set by an event in the same cycle stays set.
- R11: irq_en_wr loads the enable mask, and irq is high exactly when a status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word |
| irq_clr_wr | input | 1 | Interrupt status clear strobe |
| irq_clr_data | input | 8 | Bits to clear (write one to clear) |
| irq_en_wr | input | 1 | Interrupt enable write strobe |
| irq_en_data | input | 8 | New interrupt enable mask |
| blk_done | input | 1 | Cipher datapath finished one 16-byte block |
| dma_done | input | 1 | Memory copy finished |
| q_empty | output | 1 | Queue holds no words |
| q_full | output | 1 | Queue holds 5 words |
| eng_busy | output | 1 | Cipher engine running |
| dma_busy | output | 1 | Memory copy in flight |
| irq_status | output | 8 | Interrupt status register |
| irq_enable | output | 8 | Interrupt enable mask |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle cipher start pulse |
| eng_blocks | output | 13 | Number of blocks for the started run |
| eng_src | output | 32 | Captured source address |
| dma_start | output | 1 | One-cycle memory copy start pulse |
| dma_dir | output | 1 | Copy direction |
| dma_words | output | 13 | Copy length in 32-bit words |
| dma_addr | output | 32 | External copy address |
| tbl_load | output | 1 | One-cycle table load pulse |
| tbl_sel | output | 1 | Table select field |
| tbl_ram | output | 1 | Internal RAM select field |
| tbl_id | output | 6 | Key-table ID field |

## Verification
The first pattern runs the cipher sequence of setup, address, start and completion with the completion marker queued early. This shows whether the done bit waits for the last block strobe and whether busy drops on that same edge. A start with no setup and an unknown opcode both raise the illegal bit. A completion marker sent while idle shows the immediate path. Memory copies in both directions tell apart the direction, length and trailing-address handling. A burst of table loads written while the engine runs fills the queue and pushes it past five. This shows the drop, the overflow bit and that the held words keep their order once the engine finishes. Clears that land in the same cycle as a new event, and changes to the enable mask, separate the write-one-to-clear behaviour from the irq masking.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int WORD_W   = 32;
    localparam int OP_LSB   = 26;
    localparam int OP_W     = 6;
    localparam int IRQ_W    = 8;
    localparam int WCNT_LSB = 12;
    localparam int WCNT_W   = 13;
    localparam int ID_LSB   = 17;
    localparam int ID_W     = 6;

    localparam logic [OP_W-1:0] OP_START = 6'h0E;
    localparam logic [OP_W-1:0] OP_SETUP = 6'h10;
    localparam logic [OP_W-1:0] OP_FINAL = 6'h11;
    localparam logic [OP_W-1:0] OP_TABLE = 6'h15;
    localparam logic [OP_W-1:0] OP_COPY  = 6'h22;

    localparam int EV_ILLEGAL  = 0;
    localparam int EV_OVERFLOW = 1;
    localparam int EV_CRYPT    = 4;
    localparam int EV_COPY     = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_SRC, S_DST, S_COPY, S_RUN
    } seq_e;

    function automatic logic [OP_W-1:0] op_of(input logic [WORD_W-1:0] w);
        return w[OP_LSB +: OP_W];
    endfunction
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
    parameter int DEPTH = 5,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign ovf     = push_req && full;
    assign do_push = push_req && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= push_data;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/cq_irq.sv
module cq_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    input  logic         en_wr,
    input  logic [W-1:0] en_data,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         irq
);
    logic [W-1:0] clr_mask;

    assign clr_mask = clr_wr ? clr_data : '0;
    assign irq      = |(status & enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_mask) | set_bits;
            if (en_wr)
                enable <= en_data;
        end
    end
endmodule

// File: rtl/cq_seq.sv
module cq_seq
    import cq_pkg::*;
#(
    parameter int BLK_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WORD_W-1:0]    head,
    input  logic                 avail,
    input  logic                 blk_done,
    input  logic                 dma_done,
    output logic                 pop,
    output logic [IRQ_W-1:0]     events,
    output logic                 eng_busy,
    output logic                 dma_busy,
    output logic                 eng_start,
    output logic [BLK_W:0]       eng_blocks,
    output logic [WORD_W-1:0]    eng_src,
    output logic                 dma_start,
    output logic                 dma_dir,
    output logic [WCNT_W-1:0]    dma_words,
    output logic [WORD_W-1:0]    dma_addr,
    output logic                 tbl_load,
    output logic                 tbl_sel,
    output logic                 tbl_ram,
    output logic [ID_W-1:0]      tbl_id
);
    localparam logic [BLK_W:0] ONE = (BLK_W + 1)'(1);

    seq_e            st;
    logic            addr_ok;
    logic            pend;
    logic [BLK_W:0]  left;
    logic [OP_W-1:0] op;
    logic            last_blk;

    assign op       = op_of(head);
    assign eng_busy = (st == S_RUN);
    assign dma_busy = (st == S_COPY);
    assign last_blk = (st == S_RUN) && blk_done && (left == ONE);

    always_comb begin
        pop    = 1'b0;
        events = '0;
        case (st)
            S_IDLE: if (avail) begin
                pop = 1'b1;
                case (op)
                    OP_START: if (!addr_ok) events[EV_ILLEGAL] = 1'b1;
                    OP_FINAL: events[EV_CRYPT] = 1'b1;
                    OP_SETUP, OP_TABLE, OP_COPY: ;
                    default:  events[EV_ILLEGAL] = 1'b1;
                endcase
            end
            S_SRC, S_DST: pop = avail;
            S_COPY: if (dma_done) events[EV_COPY] = 1'b1;
            S_RUN: begin
                pop = avail && (op == OP_FINAL);
                if (last_blk && (pend || pop))
                    events[EV_CRYPT] = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            addr_ok    <= 1'b0;
            pend       <= 1'b0;
            left       <= '0;
            eng_start  <= 1'b0;
            eng_blocks <= '0;
            eng_src    <= '0;
            dma_start  <= 1'b0;
            dma_dir    <= 1'b0;
            dma_words  <= '0;
            dma_addr   <= '0;
            tbl_load   <= 1'b0;
            tbl_sel    <= 1'b0;
            tbl_ram    <= 1'b0;
            tbl_id     <= '0;
        end else begin
            eng_start <= 1'b0;
            dma_start <= 1'b0;
            tbl_load  <= 1'b0;
            case (st)
                S_IDLE: if (avail) begin
                    case (op)
                        OP_SETUP: st <= S_SRC;
                        OP_COPY: begin
                            dma_dir   <= head[25];
                            dma_words <= head[WCNT_LSB +: WCNT_W];
                            st        <= S_DST;
                        end
                        OP_TABLE: begin
                            tbl_load <= 1'b1;
                            tbl_sel  <= head[24];
                            tbl_ram  <= head[23];
                            tbl_id   <= head[ID_LSB +: ID_W];
                        end
                        OP_START: if (addr_ok) begin
                            eng_start  <= 1'b1;
                            eng_blocks <= (BLK_W + 1)'(head[BLK_W-1:0]) + ONE;
                            left       <= (BLK_W + 1)'(head[BLK_W-1:0]) + ONE;
                            addr_ok    <= 1'b0;
                            pend       <= 1'b0;
                            st         <= S_RUN;
                        end
                        default: ;
                    endcase
                end
                S_SRC: if (avail) begin
                    eng_src <= head;
                    addr_ok <= 1'b1;
                    st      <= S_IDLE;
                end
                S_DST: if (avail) begin
                    dma_addr  <= head;
                    dma_start <= 1'b1;
                    st        <= S_COPY;
                end
                S_COPY: if (dma_done) st <= S_IDLE;
                S_RUN: begin
                    if (pop) pend <= 1'b1;
                    if (blk_done) begin
                        left <= left - ONE;
                        if (left == ONE) begin
                            st   <= S_IDLE;
                            pend <= 1'b0;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cq_front.sv
module cq_front
    import cq_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int BLK_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_wr,
    input  logic [WORD_W-1:0]     cmd_data,
    input  logic                  irq_clr_wr,
    input  logic [IRQ_W-1:0]      irq_clr_data,
    input  logic                  irq_en_wr,
    input  logic [IRQ_W-1:0]      irq_en_data,
    input  logic                  blk_done,
    input  logic                  dma_done,
    output logic                  q_empty,
    output logic                  q_full,
    output logic                  eng_busy,
    output logic                  dma_busy,
    output logic [IRQ_W-1:0]      irq_status,
    output logic [IRQ_W-1:0]      irq_enable,
    output logic                  irq,
    output logic                  eng_start,
    output logic [BLK_W:0]        eng_blocks,
    output logic [WORD_W-1:0]     eng_src,
    output logic                  dma_start,
    output logic                  dma_dir,
    output logic [WCNT_W-1:0]     dma_words,
    output logic [WORD_W-1:0]     dma_addr,
    output logic                  tbl_load,
    output logic                  tbl_sel,
    output logic                  tbl_ram,
    output logic [ID_W-1:0]       tbl_id
);
    logic [WORD_W-1:0] head;
    logic              pop, ovf;
    logic [IRQ_W-1:0]  seq_ev, all_ev;

    cq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst(rst), .push_req(cmd_wr), .push_data(cmd_data),
        .pop(pop), .head(head), .empty(q_empty), .full(q_full), .ovf(ovf)
    );

    cq_seq #(.BLK_W(BLK_W)) u_seq (
        .clk(clk), .rst(rst), .head(head), .avail(!q_empty),
        .blk_done(blk_done), .dma_done(dma_done), .pop(pop), .events(seq_ev),
        .eng_busy(eng_busy), .dma_busy(dma_busy), .eng_start(eng_start),
        .eng_blocks(eng_blocks), .eng_src(eng_src), .dma_start(dma_start),
        .dma_dir(dma_dir), .dma_words(dma_words), .dma_addr(dma_addr),
        .tbl_load(tbl_load), .tbl_sel(tbl_sel), .tbl_ram(tbl_ram), .tbl_id(tbl_id)
    );

    always_comb begin
        all_ev = seq_ev;
        all_ev[EV_OVERFLOW] = ovf;
    end

    cq_irq #(.W(IRQ_W)) u_irq (
        .clk(clk), .rst(rst), .set_bits(all_ev), .clr_wr(irq_clr_wr),
        .clr_data(irq_clr_data), .en_wr(irq_en_wr), .en_data(irq_en_data),
        .status(irq_status), .enable(irq_enable), .irq(irq)
    );
endmodule

// File: rtl/cq_front_chk.sv
module cq_front_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic       q_full,
    input logic       q_empty,
    input logic [7:0] irq_status,
    input logic       eng_start,
    input logic       eng_busy,
    input logic       dma_start,
    input logic       dma_busy,
    input logic       tbl_load
);
    AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(q_full && q_empty)); // R2
    AST_OVERFLOW_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && q_full) |=> irq_status[1]); // R2
    AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> eng_busy); // R7
    AST_COPY_MAKES_BUSY: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> dma_busy); // R4
    AST_COPY_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
        dma_start |=> !dma_start); // R4
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_start, dma_start, tbl_load})); // R3
    AST_NO_DUAL_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(eng_busy && dma_busy)); // R7
endmodule

bind cq_front cq_front_chk u_chk (.*);

// File: tb/tb_cq_front.sv
module tb_cq_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        irq_clr_wr = 1'b0;
    logic [7:0]  irq_clr_data = '0;
    logic        irq_en_wr = 1'b0;
    logic [7:0]  irq_en_data = '0;
    logic        blk_done = 1'b0;
    logic        dma_done = 1'b0;
    logic        q_empty, q_full, eng_busy, dma_busy, irq;
    logic [7:0]  irq_status, irq_enable;
    logic        eng_start, dma_start, dma_dir, tbl_load, tbl_sel, tbl_ram;
    logic [12:0] eng_blocks, dma_words;
    logic [31:0] eng_src, dma_addr;
    logic [5:0]  tbl_id;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    cq_front dut (.*);

    // reference model state
    logic [31:0] q[$];
    int          m_st;
    bit          m_ok, m_pend;
    int          m_left;
    logic [7:0]  m_ist, m_ien, s;
    bit          m_es, m_ds, m_tl, m_dir, m_tsel, m_tram;
    logic [12:0] m_blocks, m_words;
    logic [31:0] m_src, m_addr, w;
    logic [5:0]  m_id, op;
    int          n;
    bit          popd;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            q.delete(); m_st = 0; m_ok = 0; m_pend = 0; m_left = 0;
            m_ist = 0; m_ien = 0; m_es = 0; m_ds = 0; m_tl = 0;
            m_dir = 0; m_tsel = 0; m_tram = 0; m_blocks = 0; m_words = 0;
            m_src = 0; m_addr = 0; m_id = 0;
        end else begin
            s = 0; m_es = 0; m_ds = 0; m_tl = 0; popd = 0;
            n = q.size();
            w = (n > 0) ? q[0] : 32'h0;
            op = w[31:26];
            case (m_st)
                0: if (n > 0) begin
                    void'(q.pop_front());
                    if (op == 6'h10) m_st = 1;
                    else if (op == 6'h22) begin m_dir = w[25]; m_words = w[24:12]; m_st = 2; end
                    else if (op == 6'h15) begin m_tl = 1; m_tsel = w[24]; m_tram = w[23]; m_id = w[22:17]; end
                    else if (op == 6'h0E) begin
                        if (m_ok) begin
                            m_es = 1; m_blocks = 13'(w[11:0]) + 13'd1;
                            m_left = int'(w[11:0]) + 1; m_ok = 0; m_pend = 0; m_st = 4;
                        end else s[0] = 1;
                    end
                    else if (op == 6'h11) s[4] = 1;
                    else s[0] = 1;
                end
                1: if (n > 0) begin m_src = q.pop_front(); m_ok = 1; m_st = 0; end
                2: if (n > 0) begin m_addr = q.pop_front(); m_ds = 1; m_st = 3; end
                3: if (dma_done) begin s[5] = 1; m_st = 0; end
                4: begin
                    if (n > 0 && op == 6'h11) begin void'(q.pop_front()); popd = 1; end
                    if (blk_done) begin
                        if (m_left == 1) begin
                            if (m_pend || popd) s[4] = 1;
                            m_st = 0; m_pend = 0;
                        end else if (popd) m_pend = 1;
                        m_left--;
                    end else if (popd) m_pend = 1;
                end
                default: ;
            endcase
            if (cmd_wr) begin
                if (n == 5) s[1] = 1;
                else q.push_back(cmd_data);
            end
            if (irq_en_wr) m_ien = irq_en_data;
            m_ist = (m_ist & ~(irq_clr_wr ? irq_clr_data : 8'h0)) | s;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 q_empty", q_empty, q.size() == 0);
            chk("R2 q_full", q_full, q.size() == 5);
            chk("R7 eng_busy", eng_busy, m_st == 4);
            chk("R4 dma_busy", dma_busy, m_st == 3);
            chk("R8 R9 R10 irq_status", irq_status, m_ist);
            chk("R11 irq_enable", irq_enable, m_ien);
            chk("R11 irq", irq, |(m_ist & m_ien));
            chk("R6 eng_start", eng_start, m_es);
            chk("R6 eng_blocks", eng_blocks, m_blocks);
            chk("R5 eng_src", eng_src, m_src);
            chk("R4 dma_start", dma_start, m_ds);
            chk("R4 dma_dir", dma_dir, m_dir);
            chk("R4 dma_words", dma_words, m_words);
            chk("R4 dma_addr", dma_addr, m_addr);
            chk("R3 tbl_load", tbl_load, m_tl);
            chk("R3 tbl_fields", {tbl_sel, tbl_ram, tbl_id}, {m_tsel, m_tram, m_id});
        end
    end

    // stand-ins for the cipher datapath and the DMA unit
    always @(negedge clk) begin
        blk_done <= eng_busy && (cyc % 3 == 0);
        dma_done <= dma_busy && (cyc % 4 == 1);
    end

    task automatic put(input logic [31:0] v);
        @(negedge clk); cmd_wr = 1; cmd_data = v;
    endtask
    task automatic idle(input int k);
        @(negedge clk); cmd_wr = 0; irq_clr_wr = 0; irq_en_wr = 0;
        repeat (k) @(negedge clk);
    endtask
    task automatic clear(input logic [7:0] m);
        @(negedge clk); cmd_wr = 0; irq_clr_wr = 1; irq_clr_data = m;
    endtask
    task automatic set_en(input logic [7:0] m);
        @(negedge clk); cmd_wr = 0; irq_en_wr = 1; irq_en_data = m;
    endtask

    function automatic logic [31:0] mk(input logic [5:0] o, input logic [25:0] f);
        return {o, f};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset empty", q_empty, 1'b1);
        chk("R1 reset busy", {eng_busy, dma_busy, q_full}, 3'b000);
        chk("R1 reset status", {irq_status, irq_enable, irq}, 17'h0);
        chk("R1 reset pulses", {eng_start, dma_start, tbl_load}, 3'b000);
        chk("R1 reset src", eng_src, 32'h0);
        cmp_on = 1;

        set_en(8'h33);                                                       // R11
        put(mk(6'h15, (26'd1 << 24) | (26'd1 << 23) | (26'(6'h8 | 6'h3) << 17))); // R3
        put(mk(6'h15, 26'(6'h8 | 6'h5) << 17));                              // R3
        idle(4);
        put(mk(6'h0E, 26'd2));                                               // R6 no address
        idle(3);
        chk("R6 illegal start", irq_status[0], 1'b1);
        clear(8'h01);                                                        // R10
        idle(1);
        chk("R10 cleared", irq_status[0], 1'b0);
        put(mk(6'h3F, 26'h0));                                               // R9
        idle(3);
        chk("R9 unknown opcode", irq_status[0], 1'b1);

        put(mk(6'h10, 26'h0)); put(32'hA000_1000);                           // R5
        put(mk(6'h0E, 26'd2)); put(mk(6'h11, 26'h0));                        // R6 R7 R8
        idle(30);
        chk("R8 crypt done", irq_status[4], 1'b1);
        clear(8'hFF);
        put(mk(6'h22, 26'd16 << 12)); put(32'h8000_0040);                    // R4 inbound
        idle(12);
        put(mk(6'h22, (26'd1 << 25) | (26'd16 << 12))); put(32'h8000_0100);  // R4 outbound
        idle(12);
        chk("R4 copy done", irq_status[5], 1'b1);

        put(mk(6'h10, 26'h0)); put(32'h1234_5670);
        put(mk(6'h0E, 26'd19));                                              // 20 blocks
        idle(3);
        for (int i = 0; i < 7; i++) put(mk(6'h15, 26'(i) << 17));           // R2 burst
        put(mk(6'h11, 26'h0));
        idle(2);
        chk("R2 overflow", irq_status[1], 1'b1);
        idle(90);
        put(mk(6'h11, 26'h0));                                               // R8 idle path
        clear(8'h10);                                                        // R10 set wins race
        idle(4);
        set_en(8'h00);                                                       // R11 mask off
        idle(3);
        chk("R11 masked", irq, 1'b0);
        set_en(8'hFF);
        clear(8'hFF);
        idle(4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule